// File: doc/BRIEF.md
# Timer interrupt reinjection controller

This block sits between a timer that strobes once per expiration and an interrupt line toward a processor. It keeps a count of expirations that have not yet been serviced. It replays them as separate interrupt pulses, so ticks that arrive while software is busy are not lost. It never has more than one interrupt in flight: a new pulse is only released after the previous one has been acknowledged.

The pending count goes down by one on each acknowledge and never drops below zero. It stops at its largest value instead of wrapping. Three events throw away the backlog and re-arm delivery: unmasking the interrupt, reprogramming the timer, and reset. The count can be read on an output port. The interrupt itself is a single-clock pulse, an edge and not a level.

Top module: `tr_reinject`

## Requirements
- R1: After reset `pend_o` is 0, `irq_o` is 0, and the controller is ready to issue, so the first tick gives an interrupt without an acknowledge.
- R2: A cycle with `tick_i` high and `ack_i`, `unmask_i` and `reprogram_i` low raises `pend_o` by one on the next clock.
- R3: A tick with `pend_o` at 2^CNT_W-1 (255 by default) leaves the count at 2^CNT_W-1; it never wraps to 0.
- R4: A cycle with `ack_i` high and `tick_i` low lowers `pend_o` by one, but a count of 0 stays at 0; the acknowledge re-arms issuing.
- R5: A tick and an acknowledge in the same cycle leave `pend_o` unchanged and re-arm issuing.
- R6: In a cycle where the registered count is nonzero, issuing is armed and no clear event is present, the controller issues; `irq_o` is high in the following cycle, and issuing disarms.
- R7: After an issued interrupt, no further interrupt appears until an acknowledge, unmask or reprogram event, whatever the pending count.
- R8: `irq_o` is never high for two consecutive cycles.
- R9: A cycle with `unmask_i` high sets `pend_o` to 0 on the next clock and re-arms issuing.
- R10: A cycle with `reprogram_i` high sets `pend_o` to 0 on the next clock and re-arms issuing.
- R11: A clear event (unmask or reprogram) takes priority over a tick or acknowledge in the same cycle, and it also suppresses an interrupt that would have been issued in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe per timer expiration |
| ack_i | input | 1 | One-cycle strobe when the interrupt is acknowledged |
| unmask_i | input | 1 | One-cycle strobe when the interrupt line is unmasked |
| reprogram_i | input | 1 | One-cycle strobe when the timer is reprogrammed |
| irq_o | output | 1 | One-cycle interrupt pulse |
| pend_o | output | CNT_W | Current count of undelivered expirations |

## Verification
The bench goes after the saturation point: a design that wraps would show 0 after 256 ticks instead of 255. It drives ticks and acknowledges in the same cycle, where a design that applies both updates in the wrong order would drift the count. It checks that a clear in the cycle where an issue is due suppresses that issue; a design that lets it through would send a spurious interrupt after the backlog was discarded. It also sends a run of ticks without acknowledges, where a design with no throttle would pulse on every cycle, and acknowledges at a count of 0, where a design with no floor would underflow to 255.

// File: rtl/tr_pkg.sv
package tr_pkg;

    // Operation applied to the backlog counter in one cycle
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_INC  = 2'd1,
        CNT_DEC  = 2'd2,
        CNT_CLR  = 2'd3
    } cnt_op_e;

    // Delivery state: armed flag and registered pulse
    typedef struct packed {
        logic armed;
        logic irq;
    } issue_st_t;

endpackage

// File: rtl/tr_backlog.sv
module tr_backlog
    import tr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_op_e      op_i,
    output logic [W-1:0] cnt_o,
    output logic         nz_o
);

    localparam logic [W-1:0] CNT_TOP  = {W{1'b1}};
    localparam logic [W-1:0] CNT_ZERO = '0;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unique case (op_i)
            CNT_INC: begin
                if (cnt_q != CNT_TOP) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            CNT_DEC: begin
                if (cnt_q != CNT_ZERO) begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            CNT_CLR:  cnt_d = CNT_ZERO;
            default:  cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_ZERO;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;
    assign nz_o  = (cnt_q != CNT_ZERO);

endmodule

// File: rtl/tr_issue.sv
module tr_issue
    import tr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nz_i,
    input  logic ack_i,
    input  logic clr_i,
    output logic irq_o
);

    issue_st_t st_d, st_q;
    logic      fire;

    always_comb begin
        fire     = nz_i & st_q.armed & ~clr_i;
        st_d     = st_q;
        st_d.irq = fire;
        if (clr_i) begin
            st_d.armed = 1'b1;
        end else if (fire) begin
            st_d.armed = 1'b0;
        end else if (ack_i) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{armed: 1'b1, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

endmodule

// File: rtl/tr_reinject.sv
module tr_reinject
    import tr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ack_i,
    input  logic             unmask_i,
    input  logic             reprogram_i,
    output logic             irq_o,
    output logic [CNT_W-1:0] pend_o
);

    logic    clr;
    logic    nz;
    cnt_op_e op;

    always_comb begin
        clr = unmask_i | reprogram_i;
        if (clr) begin
            op = CNT_CLR;
        end else if (tick_i && !ack_i) begin
            op = CNT_INC;
        end else if (ack_i && !tick_i) begin
            op = CNT_DEC;
        end else begin
            op = CNT_HOLD;
        end
    end

    tr_backlog #(.W(CNT_W)) u_backlog (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (op),
        .cnt_o (pend_o),
        .nz_o  (nz)
    );

    tr_issue u_issue (
        .clk   (clk),
        .rst_n (rst_n),
        .nz_i  (nz),
        .ack_i (ack_i),
        .clr_i (clr),
        .irq_o (irq_o)
    );

endmodule

// File: rtl/tr_reinject_chk.sv
module tr_reinject_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_i,
    input logic         ack_i,
    input logic         unmask_i,
    input logic         reprogram_i,
    input logic         irq_o,
    input logic [W-1:0] pend_o
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic clr;
    logic outstanding_q;

    assign clr = unmask_i | reprogram_i;

    // An interrupt is in flight from its pulse until acknowledge or clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outstanding_q <= 1'b0;
        end else if (clr || ack_i) begin
            outstanding_q <= 1'b0;
        end else if (irq_o) begin
            outstanding_q <= 1'b1;
        end
    end

    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !ack_i && !clr && pend_o != TOP) |=> (pend_o == W'($past(pend_o) + 1'b1)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !ack_i && !clr && pend_o == TOP) |=> (pend_o == TOP));

    p_dec_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !tick_i && !clr) |=>
            (pend_o == (($past(pend_o) == '0) ? '0 : W'($past(pend_o) - 1'b1))));

    p_tick_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ack_i && !clr) |=> $stable(pend_o));

    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(pend_o) != '0));

    p_single_flight_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !outstanding_q);

    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    p_clear_r9_r10_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pend_o == '0 && !irq_o));

endmodule

bind tr_reinject tr_reinject_chk #(.W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .ack_i       (ack_i),
    .unmask_i    (unmask_i),
    .reprogram_i (reprogram_i),
    .irq_o       (irq_o),
    .pend_o      (pend_o)
);

// File: tb/tr_reinject_tb.sv
module tr_reinject_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int TOP        = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_i = 1'b0;
    logic         ack_i = 1'b0;
    logic         unmask_i = 1'b0;
    logic         reprogram_i = 1'b0;
    logic         irq_o;
    logic [W-1:0] pend_o;

    int checks = 0;
    int fails  = 0;
    int irq_seen = 0;
    int irq_run  = 0;
    bit done = 1'b0;
    string phase = "R1";

    // Behavioural reference state
    int m_pend  = 0;
    bit m_armed = 1'b1;
    bit m_irq   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tr_reinject #(.CNT_W(W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .ack_i       (ack_i),
        .unmask_i    (unmask_i),
        .reprogram_i (reprogram_i),
        .irq_o       (irq_o),
        .pend_o      (pend_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Reference model: one update per clock from the requirement text
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend  <= 0;
            m_armed <= 1'b1;
            m_irq   <= 1'b0;
        end else begin
            bit wipe, go;
            int p;
            wipe = unmask_i || reprogram_i;
            go   = !wipe && (m_pend > 0) && m_armed;
            m_irq <= go;
            p = m_pend;
            if (wipe) p = 0;
            else if (tick_i && !ack_i) p = (p < TOP) ? p + 1 : TOP;
            else if (ack_i && !tick_i) p = (p > 0) ? p - 1 : 0;
            m_pend <= p;
            if (wipe) m_armed <= 1'b1;
            else if (go) m_armed <= 1'b0;
            else if (ack_i) m_armed <= 1'b1;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({phase, " pend"}, int'(pend_o), m_pend);
            check({phase, " irq"}, int'(irq_o), int'(m_irq));
            if (irq_o) begin
                irq_seen++;
                irq_run++;
                check("R8 pulse width", irq_run, 1);
            end else begin
                irq_run = 0;
            end
        end
    end

    task automatic drive(input bit t, input bit a, input bit u, input bit r);
        tick_i = t; ack_i = a; unmask_i = u; reprogram_i = r;
        @(negedge clk);
        tick_i = 1'b0; ack_i = 1'b0; unmask_i = 1'b0; reprogram_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 pend after reset", int'(pend_o), 0);
        check("R1 irq after reset", int'(irq_o), 0);

        // R2, R6, R7: three ticks, one interrupt only
        phase = "R2";
        drive(1, 0, 0, 0); drive(1, 0, 0, 0); drive(1, 0, 0, 0);
        check("R2 count after 3 ticks", int'(pend_o), 3);
        idle(3);
        check("R6 first interrupt issued", irq_seen, 1);
        phase = "R7";
        idle(5);
        check("R7 no second irq without ack", irq_seen, 1);

        // R4: acknowledge decrements and re-arms
        phase = "R4";
        drive(0, 1, 0, 0);
        check("R4 count after ack", int'(pend_o), 2);
        idle(3);
        check("R4 ack re-arms issue", irq_seen, 2);
        drive(0, 1, 0, 0); drive(0, 1, 0, 0);
        check("R4 count drained", int'(pend_o), 0);
        drive(0, 1, 0, 0);
        check("R4 floor at zero", int'(pend_o), 0);
        idle(3);

        // R3: saturation
        phase = "R3";
        for (int i = 0; i < 300; i++) drive(1, 0, 0, 0);
        check("R3 saturated count", int'(pend_o), TOP);
        drive(1, 0, 0, 0);
        check("R3 no wrap", int'(pend_o), TOP);

        // R9: unmask discards backlog
        phase = "R9";
        drive(0, 0, 1, 0);
        check("R9 unmask clears", int'(pend_o), 0);
        base = irq_seen;
        idle(4);
        check("R9 no irq after unmask", irq_seen - base, 0);

        // R5: tick and ack together
        phase = "R5";
        base = irq_seen;
        drive(1, 0, 0, 0); drive(1, 0, 0, 0);
        drive(1, 1, 0, 0);
        check("R5 count held", int'(pend_o), 2);
        idle(3);
        check("R5 flag re-armed", irq_seen - base, 2);

        // R10: reprogram discards backlog
        phase = "R10";
        drive(0, 0, 0, 1);
        check("R10 reprogram clears", int'(pend_o), 0);
        idle(3);

        // R11: clear wins over tick, and suppresses a due issue
        phase = "R11";
        drive(1, 0, 1, 0);
        check("R11 clear beats tick", int'(pend_o), 0);
        base = irq_seen;
        drive(1, 0, 0, 0);
        drive(0, 0, 0, 1);
        idle(4);
        check("R11 due issue suppressed", irq_seen - base, 0);
        check("R11 count after clear", int'(pend_o), 0);

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule